// File: doc/BRIEF.md
# Zero-Suppressing Serial Channel Digitizer Sequencer

This block sequences the digitization of one front-end chip on a readout board. Once reset is released it runs a short initialization phase. It then waits in acquisition for triggers. When a trigger arrives, the block stores the chip's per-channel above-threshold flags in a small event buffer. The oldest stored event is then digitized by walking its channels one at a time. A channel above threshold gets a full conversion slot. The slot opens with an ADC start pulse and closes only after the converter has reported completion. A channel below threshold costs a single cycle. After the last channel comes a fixed-length readout phase, which frees the event's buffer slot. The block then returns to acquisition.

The buffer has several slots, so triggers keep being accepted while an earlier event is being digitized. The trigger source sees busy only when every slot is taken. A trigger that arrives while busy is dropped and counted. The hit-channel stream tells downstream logic which channel indices carried charge. Analog conversion itself happens outside the block. At the nominal 18 ns clock, a chip with two hits in 32 channels needs 42 digitization cycles instead of 192.

Top module: `zs_chan_seq`

## Requirements
- R1: After synchronous reset, `phase_o` reads 0 (init) for exactly INIT_CYC cycles and then 1 (acquire). During reset, busy, hit valid, ADC start and the lost count are all 0.
- R2: Phases only move init→acquire, acquire→digitize (2), digitize→readout (3) and readout→acquire. Readout lasts exactly RD_CYC cycles.
- R3: During digitization, a channel whose stored flag is 0 occupies exactly one cycle, and the channel index then advances by one.
- R4: A channel whose stored flag is 1 occupies at least HIT_CYC cycles. `adc_start_o` pulses only in the first of those cycles. The slot ends at the end of the first cycle, at or after cycle HIT_CYC, in which `adc_done_i` is seen (now or earlier in the slot). With prompt completion, an event with h hits takes NCH + (HIT_CYC-1)·h digitize cycles.
- R5: In the first cycle of each hit slot, `hit_vld_o` pulses with `hit_ch_o` equal to the channel index, which also equals `ch_sel_o`. Within an event, indices come out in ascending order, and only for channels whose flag is 1.
- R6: Events are digitized in trigger order. `slot_o` shows the slot being digitized, and slots are used in sequence 0,1,…,DEPTH-1,0,… A slot is freed in the last readout cycle.
- R7: `busy_o` is 1 exactly while all DEPTH slots are occupied.
- R8: A trigger sampled while `busy_o` is 1 is not stored, and `lost_o` increments by one. A trigger sampled during init is ignored and not counted.
- R9: The hit flags are captured in the cycle the trigger is sampled. Later changes on `hit_i` do not affect that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger, sampled on each rising edge |
| hit_i | input | NCH | Per-channel above-threshold flags |
| adc_done_i | input | 1 | Converter completion strobe |
| phase_o | output | 2 | 0 init, 1 acquire, 2 digitize, 3 readout |
| ch_sel_o | output | $clog2(NCH) | Channel currently addressed |
| adc_start_o | output | 1 | Conversion start pulse |
| slot_o | output | $clog2(DEPTH) | Buffer slot being digitized |
| busy_o | output | 1 | All buffer slots occupied |
| hit_vld_o | output | 1 | Hit-channel stream valid |
| hit_ch_o | output | $clog2(NCH) | Hit-channel stream index |
| lost_o | output | LOST_W | Count of triggers dropped while busy |

## Verification
The hardest state to reach is a full buffer while the oldest event is still in digitization. In that state, extra triggers must be dropped and counted, and the stored events must still come out in order with their own flags. The stimulus reaches it with a burst of six back-to-back triggers, each with a distinct flag pattern. Digitization cannot free a slot within six cycles, so the last two triggers are lost. A second hard case is a conversion whose completion arrives long after the nominal slot. For this, the automatic converter model is switched off and completion is pulsed by hand nine cycles after the start, which stretches one hit slot to ten cycles.

// File: rtl/zs_chan_pkg.sv
package zs_chan_pkg;
  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_ACQ  = 2'd1,
    PH_DIGI = 2'd2,
    PH_READ = 2'd3
  } phase_e;
endpackage

// File: rtl/zs_evbuf.sv
module zs_evbuf #(
  parameter int NCH    = 32,
  parameter int DEPTH  = 4,
  parameter int LOST_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic                       trig_i,
  input  logic [NCH-1:0]             hit_i,
  input  logic                       pop_i,
  output logic [NCH-1:0]             rd_map_o,
  output logic [$clog2(DEPTH)-1:0]   rd_slot_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [LOST_W-1:0]          lost_o
);
  localparam int SL_W  = $clog2(DEPTH);
  localparam int CNT_W = SL_W + 1;

  logic [NCH-1:0]   mem [DEPTH];
  logic [SL_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [LOST_W-1:0] lost;
  logic push;

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push    = trig_i & en_i & ~full_o;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      lost   <= '0;
    end else begin
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop_i);
      if (push)
        wr_ptr <= (wr_ptr == SL_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)
        rd_ptr <= (rd_ptr == SL_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (trig_i & en_i & full_o)
        lost <= lost + 1'b1;
    end
  end

  assign rd_map_o  = mem[rd_ptr];
  assign rd_slot_o = rd_ptr;
  assign lost_o    = lost;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R7
  AST_LOST_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    !full_o |=> $stable(lost_o)); // R8
endmodule

// File: rtl/zs_scan.sv
module zs_scan #(
  parameter int NCH     = 32,
  parameter int HIT_CYC = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [NCH-1:0]           map_i,
  input  logic                     adc_done_i,
  output logic                     active_o,
  output logic                     last_o,
  output logic [$clog2(NCH)-1:0]   ch_o,
  output logic                     adc_start_o
);
  localparam int CH_W  = $clog2(NCH);
  localparam int SUB_W = $clog2(HIT_CYC + 1);

  logic             active, seen;
  logic [CH_W-1:0]  ch;
  logic [SUB_W-1:0] sub;
  logic cur_hit, slot_end, step;

  assign cur_hit  = map_i[ch];
  assign slot_end = (sub == SUB_W'(HIT_CYC-1)) & (seen | adc_done_i);
  assign step     = active & (~cur_hit | slot_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ch     <= '0;
      sub    <= '0;
      seen   <= 1'b0;
    end else if (start_i) begin
      active <= 1'b1;
      ch     <= '0;
      sub    <= '0;
      seen   <= 1'b0;
    end else if (active) begin
      if (step) begin
        sub  <= '0;
        seen <= 1'b0;
        if (ch == CH_W'(NCH-1)) active <= 1'b0;
        else                    ch     <= ch + 1'b1;
      end else begin
        seen <= seen | adc_done_i;
        if (sub != SUB_W'(HIT_CYC-1)) sub <= sub + 1'b1;
      end
    end
  end

  assign active_o    = active;
  assign last_o      = step & (ch == CH_W'(NCH-1));
  assign ch_o        = ch;
  assign adc_start_o = active & cur_hit & (sub == '0);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |=> !adc_start_o); // R4
  AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (active && !cur_hit && ch != CH_W'(NCH-1) && !start_i)
      |=> (ch == CH_W'($past(ch) + 1'b1))); // R3
endmodule

// File: rtl/zs_chan_seq.sv
module zs_chan_seq
  import zs_chan_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int DEPTH    = 4,
  parameter int HIT_CYC  = 6,
  parameter int INIT_CYC = 4,
  parameter int RD_CYC   = 3,
  parameter int LOST_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       trig_i,
  input  logic [NCH-1:0]             hit_i,
  input  logic                       adc_done_i,
  output logic [1:0]                 phase_o,
  output logic [$clog2(NCH)-1:0]     ch_sel_o,
  output logic                       adc_start_o,
  output logic [$clog2(DEPTH)-1:0]   slot_o,
  output logic                       busy_o,
  output logic                       hit_vld_o,
  output logic [$clog2(NCH)-1:0]     hit_ch_o,
  output logic [LOST_W-1:0]          lost_o
);
  localparam int CH_W  = $clog2(NCH);
  localparam int TMR_W = $clog2((INIT_CYC > RD_CYC ? INIT_CYC : RD_CYC) + 1);

  phase_e          phase;
  logic [TMR_W-1:0] tmr;
  logic [NCH-1:0]  rd_map;
  logic            empty, full, pop, start, scan_act, scan_last, a_start;
  logic [CH_W-1:0] ch;

  assign pop   = (phase == PH_READ) && (tmr == TMR_W'(RD_CYC-1));
  assign start = (phase == PH_ACQ) && !empty;

  zs_evbuf #(.NCH(NCH), .DEPTH(DEPTH), .LOST_W(LOST_W)) u_buf (
    .clk(clk), .rst(rst), .en_i(phase != PH_INIT), .trig_i(trig_i),
    .hit_i(hit_i), .pop_i(pop), .rd_map_o(rd_map), .rd_slot_o(slot_o),
    .empty_o(empty), .full_o(full), .lost_o(lost_o)
  );

  zs_scan #(.NCH(NCH), .HIT_CYC(HIT_CYC)) u_scan (
    .clk(clk), .rst(rst), .start_i(start), .map_i(rd_map),
    .adc_done_i(adc_done_i), .active_o(scan_act), .last_o(scan_last),
    .ch_o(ch), .adc_start_o(a_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INIT;
      tmr   <= '0;
    end else begin
      unique case (phase)
        PH_INIT: begin
          if (tmr == TMR_W'(INIT_CYC-1)) begin
            phase <= PH_ACQ;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PH_ACQ:  if (!empty) phase <= PH_DIGI;
        PH_DIGI: if (scan_last) begin
          phase <= PH_READ;
          tmr   <= '0;
        end
        PH_READ: begin
          if (tmr == TMR_W'(RD_CYC-1)) begin
            phase <= PH_ACQ;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: phase <= PH_INIT;
      endcase
    end
  end

  assign phase_o     = phase;
  assign ch_sel_o    = ch;
  assign adc_start_o = a_start;
  assign hit_vld_o   = a_start;
  assign hit_ch_o    = ch;
  assign busy_o      = full;

  AST_READ_EXIT: assert property (@(posedge clk) disable iff (rst)
    phase == PH_READ |=> (phase == PH_READ || phase == PH_ACQ)); // R2
  AST_INIT_EXIT: assert property (@(posedge clk) disable iff (rst)
    phase == PH_INIT |=> (phase == PH_INIT || phase == PH_ACQ)); // R1
  AST_DIGI_SCANS: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DIGI |-> scan_act); // R2
  AST_STREAM_IN_DIGI: assert property (@(posedge clk) disable iff (rst)
    hit_vld_o |-> phase == PH_DIGI); // R5
endmodule

// File: tb/zs_chan_seq_bench.sv
`timescale 1ns/1ps
module zs_chan_seq_bench;
  localparam int NCH = 32, DEPTH = 4, HIT_CYC = 6, INIT_CYC = 4, RD_CYC = 3;
  localparam int NV = 5;
  localparam logic [31:0] TV_MAP [NV] = '{32'h0000_0000, 32'hFFFF_FFFF,
                                          32'h8000_0001, 32'h0001_0000,
                                          32'hA5A5_A5A5};
  localparam int TV_DC [NV] = '{32, 192, 42, 37, 112};

  logic clk = 0, rst = 1, trig = 0, adc_done, fast_adc = 1, man_done = 0;
  logic [31:0] hit = '0;
  logic [1:0] phase, dly = '0;
  logic [4:0] ch_sel, hit_ch;
  logic [1:0] slot;
  logic adc_start, busy, hit_vld;
  logic [7:0] lost;

  always #5 clk = ~clk;
  assign adc_done = fast_adc ? dly[1] : man_done;
  always @(negedge clk) dly <= {dly[0], adc_start};

  zs_chan_seq u_zs_chan_seq (
    .clk(clk), .rst(rst), .trig_i(trig), .hit_i(hit), .adc_done_i(adc_done),
    .phase_o(phase), .ch_sel_o(ch_sel), .adc_start_o(adc_start),
    .slot_o(slot), .busy_o(busy), .hit_vld_o(hit_vld), .hit_ch_o(hit_ch),
    .lost_o(lost)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor of outputs, sampled at the falling edge
  int icyc = 0, dc = 0, st = 0, rc = 0, oe = 0, last = -1, bad_tr = 0, ev_n = 0;
  logic [31:0] cm = '0;
  logic [1:0] prev = 0, cur_slot = 0;
  logic [31:0] ev_map [16];
  int ev_dc [16], ev_st [16], ev_oe [16], ev_rc [16], ev_slot [16];
  always @(negedge clk) begin
    if (rst) begin
      prev = 0;
    end else begin
      if (phase == 0) icyc++;
      if (phase == 2) begin
        dc++;
        if (adc_start) st++;
        if (hit_vld) begin
          if (int'(hit_ch) <= last) oe++;
          if (hit_ch != ch_sel) oe++;
          last = int'(hit_ch);
          cm[hit_ch] = 1'b1;
        end
        cur_slot = slot;
      end
      if (phase == 3) rc++;
      if (!(phase == prev || (prev == 0 && phase == 1) || (prev == 1 && phase == 2) ||
            (prev == 2 && phase == 3) || (prev == 3 && phase == 1))) bad_tr++;
      if (prev == 2 && phase == 3 && ev_n < 16) begin
        ev_map[ev_n] = cm; ev_dc[ev_n] = dc; ev_st[ev_n] = st;
        ev_oe[ev_n] = oe; ev_slot[ev_n] = int'(cur_slot);
        ev_n++;
        dc = 0; st = 0; oe = 0; cm = '0; last = -1;
      end
      if (prev == 3 && phase != 3 && ev_n > 0) begin
        ev_rc[ev_n-1] = rc; rc = 0;
      end
      prev = phase;
    end
  end

  task automatic check_event(input int idx, input logic [31:0] m, input int exp_dc);
    chk(ev_map[idx] == m, "R5/R9 hit stream set", ev_map[idx], m);
    chk(ev_dc[idx] == exp_dc, "R3/R4 digitize cycles", ev_dc[idx], exp_dc);
    chk(ev_st[idx] == $countones(m), "R4 adc start count", ev_st[idx], $countones(m));
    chk(ev_oe[idx] == 0, "R5 ascending stream", ev_oe[idx], 0);
    chk(ev_slot[idx] == idx % DEPTH, "R6 slot sequence", ev_slot[idx], idx % DEPTH);
    chk(ev_rc[idx] == RD_CYC, "R2 readout length", ev_rc[idx], RD_CYC);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam logic [31:0] BM [6] = '{32'h0000_0001, 32'h0000_0003, 32'h8000_0000,
                                     32'h0000_F000, 32'h0F0F_0000, 32'h00FF_00FF};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 0, "R1 reset phase", phase, 0);
    chk(busy == 0 && hit_vld == 0 && adc_start == 0, "R1 reset outputs", {busy, hit_vld, adc_start}, 0);
    chk(lost == 0, "R1 reset lost", lost, 0);
    rst = 0;
    // R8 trigger during init is ignored
    trig = 1; hit = '1;
    @(negedge clk); trig = 0; hit = '0;
    repeat (20) @(negedge clk);
    chk(icyc == INIT_CYC, "R1 init length", icyc, INIT_CYC);
    chk(phase == 1, "R1 acquire after init", phase, 1);
    chk(ev_n == 0, "R8 init trigger not stored", ev_n, 0);
    chk(lost == 0, "R8 init trigger not counted", lost, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      trig = 1; hit = TV_MAP[i];
      @(negedge clk);
      trig = 0; hit = ~TV_MAP[i];   // R9 later flag changes ignored
      repeat (230) @(negedge clk);
      chk(ev_n == i + 1, "R6 event count", ev_n, i + 1);
      check_event(i, TV_MAP[i], TV_DC[i]);
    end

    // R4 late completion stretches a hit slot
    fast_adc = 0;
    trig = 1; hit = 32'h0000_0100;
    @(negedge clk); trig = 0; hit = '0;
    for (int g = 0; g < 100 && !adc_start; g++) @(negedge clk);
    repeat (9) @(posedge clk);
    @(negedge clk); man_done = 1;
    @(negedge clk); man_done = 0;
    repeat (80) @(negedge clk);
    fast_adc = 1;
    check_event(NV, 32'h0000_0100, 31 + 10);

    // burst to fill the buffer: R7, R8, R6
    @(negedge clk); trig = 1; hit = BM[0];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(busy == (k >= 3), "R7 busy when full", busy, (k >= 3));
      if (k < 5) hit = BM[k + 1];
      else begin trig = 0; hit = '0; end
    end
    chk(lost == 2, "R8 lost count", lost, 2);
    repeat (600) @(negedge clk);
    for (int e = 0; e < 4; e++)
      check_event(NV + 1 + e, BM[e], 32 + (HIT_CYC - 1) * $countones(BM[e]));
    chk(ev_n == NV + 5, "R8 dropped triggers never digitized", ev_n, NV + 5);
    chk(busy == 0, "R7 busy clears", busy, 0);
    chk(bad_tr == 0, "R2 phase order", bad_tr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule